// File: doc/BRIEF.md
# I2C Data-Line Setup/Hold Output Timer

This block decides the cycle in which a new value appears on the I2C data line after the clock line falls. Both the master and the slave transmit paths use it. When a falling clock edge is reported, the block captures the next data bit. It keeps the old line value for a programmed hold count. It then drives the new bit and counts a programmed setup count. Only after that count does it raise a permit that tells the clock generator it may release the clock line high. Both counts are in system clock cycles of 10 ns. The setup count is meant to cover the bus setup requirement plus the worst-case rise or fall time of the data line.

The counts come from working copies (shadows) of the programmed values. Software may rewrite the programmed values at any time, for example before a chained operation. The shadows take the new values only when a shadow-load strobe arrives while the bus is not busy. A transfer in progress therefore keeps its timing. The data line is open-drain: the block outputs a pull-down enable.

Top module: `sda_setup_hold_timer`

## Requirements
- R1: Out of reset the pull-down enable is 0 (line released) and the permit is 1. The shadow hold count is 31 (0x1F, 310 ns) and the shadow setup count is 126 (0x7E, 1260 ns).
- R2: Take a falling clock edge sampled at edge E0 with shadow hold count H. The pull-down enable keeps its old value through the H following edges and takes the new bit at edge E0+H+1.
- R3: The permit is 0 from the edge that samples a falling clock edge until setup has completed.
- R4: With shadow setup count S, the permit returns to 1 exactly S+1 cycles after the data line takes the new bit. The line then stays stable while the permit is 1.
- R5: Open-drain encoding: a data bit of 0 sets the pull-down enable to 1, and a data bit of 1 sets it to 0.
- R6: A shadow-load strobe while the busy input is 0 copies the programmed setup and hold counts into the shadows. The next falling edge uses the new counts.
- R7: A shadow-load strobe while the busy input is 1 is ignored. The timing of following falling edges keeps the previous shadow counts.
- R8: Counts of zero give the shortest timing: the line changes one cycle after the falling edge is sampled, and the permit rises one cycle after that.
- R9: The data bit is captured in the cycle the falling edge is sampled. Later changes of the data input before the next falling edge do not change the driven value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 10 ns period |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSetup | input | CNT_W | Programmed setup count (cycles) |
| cfgHold | input | CNT_W | Programmed hold count (cycles) |
| shadowLoad | input | 1 | Strobe that copies the programmed counts into the shadows |
| xferBusy | input | 1 | High while a transfer is in flight; blocks the shadow load |
| sclFall | input | 1 | One-cycle pulse: a falling clock-line edge was observed |
| dataBit | input | 1 | Next bit to place on the data line |
| sdaOe | output | 1 | Pull-down enable for the open-drain data line |
| setupDone | output | 1 | Permit for the clock generator to release the clock line high |

## Verification
The assertions check several properties on every cycle. The permit drops after each sampled falling edge. The line value does not move in the cycle right after that edge, and it does not move while the permit is high. The shadows change only on an accepted load while not busy, and then they take the programmed values. Only the bench scenarios can show the exact hold and setup durations for each pair of counts, the reset defaults, the capture of the data bit at the falling edge, and a rejected load that leaves the following timing unchanged.

// File: rtl/sda_timer_pkg.sv
package sda_timer_pkg;
  typedef struct packed {
    logic latchBit;
    logic loadHold;
    logic loadSetup;
    logic countDown;
    logic driveBit;
    logic loadShadow;
  } timerCtl_t;

  typedef enum logic [1:0] {
    ST_DONE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_SETUP = 2'd2
  } timerState_t;
endpackage

// File: rtl/sda_timer_ctl.sv
module sda_timer_ctl
  import sda_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      shadowLoad,
  input  logic      xferBusy,
  input  logic      sclFall,
  input  logic      cntZero,
  output timerCtl_t ctl,
  output logic      setupDone
);
  timerState_t state, stateNext;

  always_comb begin
    ctl = '0;
    ctl.loadShadow = shadowLoad && !xferBusy;
    stateNext = state;
    if (sclFall) begin
      ctl.latchBit = 1'b1;
      ctl.loadHold = 1'b1;
      stateNext    = ST_HOLD;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (cntZero) begin
            ctl.driveBit  = 1'b1;
            ctl.loadSetup = 1'b1;
            stateNext     = ST_SETUP;
          end else begin
            ctl.countDown = 1'b1;
          end
        end
        ST_SETUP: begin
          if (cntZero) stateNext = ST_DONE;
          else         ctl.countDown = 1'b1;
        end
        default: stateNext = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_DONE;
    else       state <= stateNext;
  end

  assign setupDone = (state == ST_DONE);
endmodule

// File: rtl/sda_timer_dp.sv
module sda_timer_dp
  import sda_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SETUP_RST = 126,
  parameter int unsigned HOLD_RST  = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic             dataBit,
  input  timerCtl_t        ctl,
  output logic             cntZero,
  output logic             sdaOe,
  output logic [CNT_W-1:0] shSetup,
  output logic [CNT_W-1:0] shHold
);
  localparam logic [CNT_W-1:0] SetupInit = CNT_W'(SETUP_RST);
  localparam logic [CNT_W-1:0] HoldInit  = CNT_W'(HOLD_RST);

  logic [CNT_W-1:0] cnt;
  logic             pendBit;
  logic             sdaBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shSetup <= SetupInit;
      shHold  <= HoldInit;
    end else if (ctl.loadShadow) begin
      shSetup <= cfgSetup;
      shHold  <= cfgHold;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (ctl.loadHold)  cnt <= shHold;
    else if (ctl.loadSetup) cnt <= shSetup;
    else if (ctl.countDown) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendBit <= 1'b1;
      sdaBit  <= 1'b1;
    end else begin
      if (ctl.latchBit) pendBit <= dataBit;
      if (ctl.driveBit) sdaBit  <= pendBit;
    end
  end

  assign cntZero = (cnt == '0);
  assign sdaOe   = ~sdaBit;
endmodule

// File: rtl/sda_setup_hold_timer.sv
module sda_setup_hold_timer
  import sda_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SETUP_RST = 126,
  parameter int unsigned HOLD_RST  = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic             shadowLoad,
  input  logic             xferBusy,
  input  logic             sclFall,
  input  logic             dataBit,
  output logic             sdaOe,
  output logic             setupDone
);
  timerCtl_t        ctl;
  logic             cntZero;
  logic [CNT_W-1:0] shSetup;
  logic [CNT_W-1:0] shHold;

  sda_timer_ctl u_ctl (
    .clk(clk), .rstN(rstN), .shadowLoad(shadowLoad), .xferBusy(xferBusy),
    .sclFall(sclFall), .cntZero(cntZero), .ctl(ctl), .setupDone(setupDone)
  );

  sda_timer_dp #(.CNT_W(CNT_W), .SETUP_RST(SETUP_RST), .HOLD_RST(HOLD_RST)) u_dp (
    .clk(clk), .rstN(rstN), .cfgSetup(cfgSetup), .cfgHold(cfgHold),
    .dataBit(dataBit), .ctl(ctl), .cntZero(cntZero), .sdaOe(sdaOe),
    .shSetup(shSetup), .shHold(shHold)
  );
endmodule

// File: rtl/sda_timer_chk.sv
module sda_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cfgSetup,
  input logic [CNT_W-1:0] cfgHold,
  input logic             shadowLoad,
  input logic             xferBusy,
  input logic             sclFall,
  input logic             sdaOe,
  input logic             setupDone,
  input logic [CNT_W-1:0] shSetup,
  input logic [CNT_W-1:0] shHold
);
  p_permit_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |=> !setupDone);

  p_hold_first_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |=> $stable(sdaOe));

  p_line_stable_permit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (setupDone && !sclFall) |=> $stable(sdaOe));

  p_shadow_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(shadowLoad && !xferBusy) |=> ($stable(shSetup) && $stable(shHold)));

  p_shadow_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    (shadowLoad && !xferBusy) |=>
      (shSetup == $past(cfgSetup) && shHold == $past(cfgHold)));
endmodule

bind sda_setup_hold_timer sda_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgSetup(cfgSetup), .cfgHold(cfgHold),
  .shadowLoad(shadowLoad), .xferBusy(xferBusy), .sclFall(sclFall),
  .sdaOe(sdaOe), .setupDone(setupDone), .shSetup(shSetup), .shHold(shHold)
);

// File: tb/sim_sda_setup_hold_timer.sv
module sim_sda_setup_hold_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] cfgSetup = '0;
  logic [CNT_W-1:0] cfgHold = '0;
  logic shadowLoad = 1'b0;
  logic xferBusy = 1'b0;
  logic sclFall = 1'b0;
  logic dataBit = 1'b1;
  logic sdaOe;
  logic setupDone;

  int errors = 0;
  int checks = 0;
  logic expOe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sda_setup_hold_timer #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgSetup(cfgSetup), .cfgHold(cfgHold),
    .shadowLoad(shadowLoad), .xferBusy(xferBusy), .sclFall(sclFall),
    .dataBit(dataBit), .sdaOe(sdaOe), .setupDone(setupDone)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadShadow(input int s, input int h, input logic busy);
    @(negedge clk);
    cfgSetup = CNT_W'(s);
    cfgHold = CNT_W'(h);
    xferBusy = busy;
    shadowLoad = 1'b1;
    @(negedge clk);
    shadowLoad = 1'b0;
  endtask

  // One bit: the falling edge is sampled, then the hold and setup durations are measured.
  task automatic runBit(input int expH, input int expS, input string tag);
    logic bitVal;
    int n;
    bitVal = expOe;      // new bit 0 when the line is released, 1 when pulled down
    @(negedge clk);
    dataBit = bitVal;
    sclFall = 1'b1;
    @(negedge clk);
    sclFall = 1'b0;
    dataBit = ~bitVal;   // R9: a later change must not be captured
    check({tag, " R3 permit low"}, int'(setupDone), 0);
    check({tag, " R2 line held"}, int'(sdaOe), int'(expOe));
    n = 0;
    while (sdaOe == expOe && n < 400) begin
      @(negedge clk);
      n++;
    end
    check({tag, " R2 hold cycles"}, n, expH + 1);
    n = 0;
    while (!setupDone && n < 400) begin
      @(negedge clk);
      n++;
    end
    check({tag, " R4 setup cycles"}, n, expS + 1);
    check({tag, " R5 R9 driven bit"}, int'(sdaOe), int'(!bitVal));
    expOe = !bitVal;
    repeat (2) @(negedge clk);
    check({tag, " R4 line stable"}, int'(sdaOe), int'(expOe));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe reset", int'(sdaOe), 0);
    check("R1 permit reset", int'(setupDone), 1);
    rstN = 1'b1;
    @(negedge clk);
    // R1: default shadows 31/126
    runBit(31, 126, "R1 defaults");
    // R6/R8: sweep of small counts, including zero
    for (int h = 0; h < 6; h++) begin
      for (int s = 0; s < 6; s++) begin
        loadShadow(s, h, 1'b0);
        runBit(h, s, (h == 0 && s == 0) ? "R8 zero" : "R6 sweep");
      end
    end
    // R7: load while busy is ignored
    loadShadow(5, 4, 1'b0);
    loadShadow(1, 2, 1'b1);
    xferBusy = 1'b1;
    runBit(4, 5, "R7 busy load ignored");
    runBit(4, 5, "R7 busy load ignored again");
    xferBusy = 1'b0;
    // R6: the same values accepted once idle
    loadShadow(1, 2, 1'b0);
    runBit(2, 1, "R6 idle load");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule